// File: doc/BRIEF.md
# Radix-4 Booth Sequential Multiplier

This block multiplies two signed two's complement operands of `WIDTH` bits and returns their full `2*WIDTH`-bit signed product. It is a sequential unit. One adder is shared across every step. An accumulator and a multiplier shift register sit side by side, and each clock step retires two multiplier bits. On each step the block reads a three-bit overlapping window: the two low multiplier bits plus the bit that was shifted out on the previous step, which starts at zero. From that window it adds zero, plus or minus the multiplicand, or plus or minus twice the multiplicand into the accumulator. It then shifts the accumulator and multiplier pair arithmetically right by two. Because of this recoding, a run of ones in the multiplier costs no extra additions.

A client raises `start_i` while `ready_o` is high, with both operands valid in the same cycle. The operands are captured on that edge. The block is then busy for a fixed `WIDTH/2` cycles. After that it raises `done_o` for one cycle and presents the product on `product_o`. The product stays on `product_o` until the next completion. A new operation may be started in the same cycle that `done_o` is high.

Top module: `booth_radix4_mul`

## Requirements
- R1: After reset, `ready_o` is 1, `done_o` is 0 and `product_o` is all zeros.
- R2: A start is accepted on a rising edge where `start_i` and `ready_o` are both 1. `ready_o` is then 0 for exactly `WIDTH/2` cycles and returns to 1 in the same cycle that `done_o` rises.
- R3: `done_o` is 1 for exactly one cycle. That cycle begins `WIDTH/2` rising edges after the accepting edge.
- R4: In the cycle `done_o` is 1, `product_o` holds the signed product of the captured multiplicand and multiplier, as a `2*WIDTH`-bit two's complement value.
- R5: Extreme operands produce exact products. This covers the most negative value times itself, times the most positive value, times -1, and times zero.
- R6: While `ready_o` is 0, `start_i` pulses and changes on the operand inputs have no effect on the result or the timing of the operation in flight.
- R7: `product_o` changes only in a cycle where `done_o` is 1. If a new start is accepted in the `done_o` cycle, the previous product stays on `product_o` until the new operation completes.
- R8: The window {mplier[2k+1], mplier[2k], mplier[2k-1]} (with mplier[-1] = 0) is recoded as follows: 000 and 111 add nothing; 001 and 010 add the multiplicand; 011 adds twice the multiplicand; 100 subtracts twice the multiplicand; 101 and 110 subtract it. Multipliers built from repeating patterns that hit every code give exact products.
- R9: `WIDTH` must be even and at least 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to begin a multiplication |
| mcand_i | input | WIDTH | Signed multiplicand, sampled with an accepted start |
| mplier_i | input | WIDTH | Signed multiplier, sampled with an accepted start |
| ready_o | output | 1 | Block is idle and can accept a start |
| done_o | output | 1 | One-cycle pulse marking a new product |
| product_o | output | 2*WIDTH | Signed product of the last completed operation |

## Verification
Two events can fall in the same cycle: the completion of one operation, which raises `done_o` and loads a new product, and the acceptance of the next start. The bench provokes this by watching for `done_o` and driving `start_i` with fresh operands in that same cycle. It then checks three things. The finished product is compared through the scoreboard. `product_o` must still hold that product for every cycle of the new operation. The new result must arrive exactly `WIDTH/2` edges later with its own correct value. A second overlap comes from start pulses and operand changes during the busy window, which must leave the result and its timing unchanged.

// File: rtl/booth_pkg.sv
package booth_pkg;

    // Recoded action for one radix-4 digit
    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_ADD1 = 3'd1,
        OP_ADD2 = 3'd2,
        OP_SUB1 = 3'd3,
        OP_SUB2 = 3'd4
    } booth_op_e;

endpackage

// File: rtl/booth_recoder.sv
module booth_recoder
    import booth_pkg::*;
(
    input  logic [2:0] win_i,
    output booth_op_e  op_o
);

    always_comb begin
        unique case (win_i)
            3'b001, 3'b010: op_o = OP_ADD1;
            3'b011:         op_o = OP_ADD2;
            3'b100:         op_o = OP_SUB2;
            3'b101, 3'b110: op_o = OP_SUB1;
            default:        op_o = OP_NONE;
        endcase
    end

endmodule

// File: rtl/booth_addend.sv
module booth_addend
    import booth_pkg::*;
#(
    parameter int WIDTH = 16,
    localparam int AW   = WIDTH + 2
) (
    input  logic [WIDTH-1:0] mcand_i,
    input  booth_op_e        op_i,
    output logic [AW-1:0]    addend_o
);

    logic [AW-1:0] one_x;
    logic [AW-1:0] two_x;

    assign one_x = {{2{mcand_i[WIDTH-1]}}, mcand_i};
    assign two_x = {one_x[AW-2:0], 1'b0};

    always_comb begin
        unique case (op_i)
            OP_ADD1: addend_o = one_x;
            OP_ADD2: addend_o = two_x;
            OP_SUB1: addend_o = ~one_x + AW'(1);
            OP_SUB2: addend_o = ~two_x + AW'(1);
            default: addend_o = '0;
        endcase
    end

endmodule

// File: rtl/booth_step.sv
module booth_step #(
    parameter int WIDTH = 16,
    localparam int AW   = WIDTH + 2
) (
    input  logic [AW-1:0]    acc_i,
    input  logic [WIDTH-1:0] mq_i,
    input  logic [AW-1:0]    addend_i,
    output logic [AW-1:0]    acc_o,
    output logic [WIDTH-1:0] mq_o,
    output logic             prev_o
);

    logic [AW-1:0] sum;

    always_comb begin
        sum    = acc_i + addend_i;
        // arithmetic shift of the {sum, mq} pair by two places
        acc_o  = {{2{sum[AW-1]}}, sum[AW-1:2]};
        mq_o   = {sum[1:0], mq_i[WIDTH-1:2]};
        prev_o = mq_i[1];
    end

endmodule

// File: rtl/booth_radix4_mul.sv
module booth_radix4_mul
    import booth_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [WIDTH-1:0]   mcand_i,
    input  logic [WIDTH-1:0]   mplier_i,
    output logic               ready_o,
    output logic               done_o,
    output logic [2*WIDTH-1:0] product_o
);

    localparam int AW   = WIDTH + 2;
    localparam int ITER = WIDTH / 2;
    localparam int CW   = $clog2(ITER) + 1;
    localparam logic [CW-1:0] LAST = CW'(ITER - 1);

    // R9: width restrictions
    generate
        if ((WIDTH % 2) != 0 || WIDTH < 4) begin : g_bad_width
            $error("booth_radix4_mul: WIDTH must be even and at least 4");
        end
    endgenerate

    typedef struct packed {
        logic               busy;
        logic [CW-1:0]      cnt;
        logic [AW-1:0]      acc;
        logic [WIDTH-1:0]   mq;
        logic               prev;
        logic [WIDTH-1:0]   mcand;
        logic               done;
        logic [2*WIDTH-1:0] prod;
    } state_t;

    state_t st_d, st_q;

    booth_op_e        op_w;
    logic [AW-1:0]    addend_w;
    logic [AW-1:0]    acc_nx_w;
    logic [WIDTH-1:0] mq_nx_w;
    logic             prev_nx_w;

    booth_recoder u_rec (
        .win_i ({st_q.mq[1:0], st_q.prev}),
        .op_o  (op_w)
    );

    booth_addend #(.WIDTH(WIDTH)) u_add (
        .mcand_i  (st_q.mcand),
        .op_i     (op_w),
        .addend_o (addend_w)
    );

    booth_step #(.WIDTH(WIDTH)) u_step (
        .acc_i    (st_q.acc),
        .mq_i     (st_q.mq),
        .addend_i (addend_w),
        .acc_o    (acc_nx_w),
        .mq_o     (mq_nx_w),
        .prev_o   (prev_nx_w)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (start_i) begin
                st_d.busy  = 1'b1;
                st_d.cnt   = '0;
                st_d.acc   = '0;
                st_d.mq    = mplier_i;
                st_d.prev  = 1'b0;
                st_d.mcand = mcand_i;
            end
        end else begin
            st_d.acc  = acc_nx_w;
            st_d.mq   = mq_nx_w;
            st_d.prev = prev_nx_w;
            st_d.cnt  = st_q.cnt + CW'(1);
            if (st_q.cnt == LAST) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                st_d.prod = {acc_nx_w[WIDTH-1:0], mq_nx_w};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ready_o   = ~st_q.busy;
    assign done_o    = st_q.done;
    assign product_o = st_q.prod;

endmodule

// File: rtl/booth_radix4_mul_chk.sv
module booth_radix4_mul_chk #(
    parameter int WIDTH = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start_i,
    input logic [WIDTH-1:0]   mcand_i,
    input logic [WIDTH-1:0]   mplier_i,
    input logic               ready_o,
    input logic               done_o,
    input logic [2*WIDTH-1:0] product_o
);

    localparam int ITER = WIDTH / 2;
    localparam int LCW  = $clog2(ITER + 2) + 1;

    logic               past_ok;
    logic               ready_q;
    logic [LCW-1:0]     low_cnt;
    logic [2*WIDTH-1:0] cap_a;
    logic [2*WIDTH-1:0] cap_b;
    logic [2*WIDTH-1:0] ref_prod;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            past_ok <= 1'b0;
            ready_q <= 1'b1;
            low_cnt <= '0;
            cap_a   <= '0;
            cap_b   <= '0;
        end else begin
            past_ok <= 1'b1;
            ready_q <= ready_o;
            low_cnt <= ready_o ? '0 : low_cnt + LCW'(1);
            if (ready_o && start_i) begin
                cap_a <= {{WIDTH{mcand_i[WIDTH-1]}}, mcand_i};
                cap_b <= {{WIDTH{mplier_i[WIDTH-1]}}, mplier_i};
            end
        end
    end

    assign ref_prod = cap_a * cap_b;

    // R2
    accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o && start_i |=> !ready_o);

    // R2
    busy_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o && !ready_q |-> low_cnt == LCW'(ITER));

    // R3
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R2
    done_with_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ready_o);

    // R4
    product_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> product_o == ref_prod);

    // R7
    product_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && !done_o |-> $stable(product_o));

endmodule

bind booth_radix4_mul booth_radix4_mul_chk #(.WIDTH(WIDTH)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .mcand_i   (mcand_i),
    .mplier_i  (mplier_i),
    .ready_o   (ready_o),
    .done_o    (done_o),
    .product_o (product_o)
);

// File: tb/booth_radix4_mul_tb_top.sv
module booth_radix4_mul_tb_top;

    localparam int W    = 16;
    localparam int ITER = W / 2;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start_i = 1'b0;
    logic [W-1:0]   mcand_i = '0;
    logic [W-1:0]   mplier_i = '0;
    logic           ready_o;
    logic           done_o;
    logic [2*W-1:0] product_o;

    always #2 clk = ~clk;

    booth_radix4_mul #(.WIDTH(W)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .mcand_i   (mcand_i),
        .mplier_i  (mplier_i),
        .ready_o   (ready_o),
        .done_o    (done_o),
        .product_o (product_o)
    );

    typedef struct {
        logic [2*W-1:0] exp;
        int             acc_edge;
        string          tag;
    } item_t;

    item_t sb_q[$];
    int    n_run  = 0;
    int    n_fail = 0;
    int    cyc    = 0;
    bit    last_done = 1'b0;
    bit    finished  = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input logic [2*W-1:0] act,
                         input logic [2*W-1:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [2*W-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
        logic signed [2*W-1:0] ea, eb;
        ea = $signed({{W{a[W-1]}}, a});
        eb = $signed({{W{b[W-1]}}, b});
        return ea * eb;
    endfunction

    // driver: called at a negedge, returns one negedge after the accepting edge
    task automatic issue(input logic [W-1:0] a, input logic [W-1:0] b,
                         input string tag, input bit noise);
        item_t it;
        while (!ready_o) @(negedge clk);
        mcand_i  = a;
        mplier_i = b;
        start_i  = 1'b1;
        it.exp = ref_mul(a, b);
        it.acc_edge = cyc + 1;
        it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
        start_i = 1'b0;
        // R2: ready drops after acceptance
        check(ready_o == 1'b0, "R2 ready low after start", {{(2*W-1){1'b0}}, ready_o}, '0);
        if (noise) begin
            // R6: disturbances while busy
            for (int i = 0; i < ITER - 1; i++) begin
                start_i  = 1'b1;
                mcand_i  = W'($urandom);
                mplier_i = W'($urandom);
                @(negedge clk);
            end
            start_i = 1'b0;
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (done_o) begin
                item_t it;
                check(!last_done, "R3 done longer than one cycle", 1, 0);
                if (sb_q.size() == 0) begin
                    check(1'b0, "R4 unexpected done", product_o, '0);
                end else begin
                    it = sb_q.pop_front();
                    check(product_o == it.exp, it.tag, product_o, it.exp);
                    check(cyc - it.acc_edge == ITER, "R3 done latency",
                          2*W'(cyc - it.acc_edge), 2*W'(ITER));
                    check(ready_o == 1'b1, "R2 ready with done", {{(2*W-1){1'b0}}, ready_o}, 1);
                end
            end
            last_done <= done_o;
        end
    end

    task automatic drain();
        while (sb_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] mn, mx;
        logic [2*W-1:0] hold_v;
        mn = {1'b1, {(W-1){1'b0}}};
        mx = {1'b0, {(W-1){1'b1}}};

        repeat (3) @(negedge clk);
        // R1: reset state
        check(ready_o == 1'b1, "R1 ready in reset", {{(2*W-1){1'b0}}, ready_o}, 1);
        check(done_o == 1'b0, "R1 done in reset", {{(2*W-1){1'b0}}, done_o}, 0);
        check(product_o == '0, "R1 product in reset", product_o, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check(ready_o == 1'b1 && done_o == 1'b0, "R1 idle after reset",
              {{(2*W-2){1'b0}}, ready_o, done_o}, 2);

        // R4: simple mixed-sign products
        issue(W'(3), W'(5), "R4 3*5", 0); drain();
        issue(W'(-3), W'(5), "R4 -3*5", 0); drain();
        issue(W'(7), W'(-9), "R4 7*-9", 0); drain();
        issue(W'(-12), W'(-11), "R4 -12*-11", 0); drain();

        // R5: extremes
        issue(mn, mn, "R5 min*min", 0); drain();
        issue(mn, mx, "R5 min*max", 0); drain();
        issue(mx, mn, "R5 max*min", 0); drain();
        issue(mn, '1, "R5 min*-1", 0); drain();
        issue('1, mn, "R5 -1*min", 0); drain();
        issue(mn, '0, "R5 min*0", 0); drain();
        issue(mx, mx, "R5 max*max", 0); drain();
        issue('1, '1, "R5 -1*-1", 0); drain();

        // R8: multiplier patterns reaching every window code
        issue(W'(1234), {(W/2){2'b01}}, "R8 mplier 0101", 0); drain();
        issue(W'(-77), {(W/2){2'b10}}, "R8 mplier 1010", 0); drain();
        issue(W'(999), {(W/4){4'b0011}}, "R8 mplier 0011", 0); drain();
        issue(mn, {(W/4){4'b1100}}, "R8 mplier 1100", 0); drain();
        issue(W'(-5), {(W/4){4'b0110}}, "R8 mplier 0110", 0); drain();
        issue(mx, {(W/4){4'b1001}}, "R8 mplier 1001", 0); drain();
        issue(W'(321), '1, "R8 mplier all ones", 0); drain();

        // R6: disturbances while busy
        for (int k = 0; k < 20; k++) begin
            issue(W'($urandom), W'($urandom), "R6 busy noise ignored", 1);
            drain();
        end

        // R7: start accepted in the done cycle, back to back
        for (int k = 0; k < 6; k++) begin
            logic [W-1:0] a2, b2;
            logic [2*W-1:0] e1;
            issue(W'($urandom), W'($urandom), "R7 first product", 0);
            e1 = sb_q[sb_q.size()-1].exp;
            while (!done_o) @(negedge clk);
            a2 = (k == 0) ? mn : W'($urandom);
            b2 = (k == 0) ? mn : W'($urandom);
            issue(a2, b2, "R7 second product", 0);
            hold_v = product_o;
            check(hold_v == e1, "R7 product held after overlap start", hold_v, e1);
            for (int j = 0; j < ITER - 2; j++) begin
                @(negedge clk);
                check(product_o == e1, "R7 product held while busy", product_o, e1);
            end
            drain();
        end

        // R4: random operands
        for (int k = 0; k < 200; k++) begin
            issue(W'($urandom), W'($urandom), "R4 random", 0);
            if (k % 3 == 0) drain();
        end
        drain();
        repeat (ITER + 2) @(negedge clk);
        check(sb_q.size() == 0, "R4 all results delivered", 2*W'(sb_q.size()), '0);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule